// File: doc/BRIEF.md
# Serial Command Front End for a Dual Digital Potentiometer

This block is the serial slave side of a two-channel digital potentiometer controller. It samples the four wires of an SPI-style link (serial clock, data in, active-low select and active-low pause) with the system clock. It puts the incoming bits together into an identification byte and an instruction byte. It compares the identification byte with a fixed device type and two address straps. A matching frame is decoded into a single-cycle command for an external register bank. The command carries an opcode, a data-register select, a potentiometer select and, for writes, a data byte.

For the two register reads, the front end takes one byte from the bank and shifts it out on the serial output. For the status read, it builds the byte itself from a busy flag. For the step command, it sends one up or down pulse for each later serial clock until select rises. The serial output never drives itself: the block gives a data bit and an output enable, and the pad or the parent makes the tri-state.

Top module: `potspi_front`

## Requirements
- R1: The first byte after a falling select edge is the identification byte, MSB first. It must have bits 7:4 = 0101, bits 3:2 = 00 and bits 1:0 = addr_strap_i. If it does not match, the frame gives no command and no step, and SO stays released until the next falling select edge.
- R2: The second byte is sampled MSB first on rising SCK. Its bits 7:4 are the opcode and go to cmd_op_o. Bits 3:2 select the data register and go to cmd_reg_o. Bit 0 selects the potentiometer and goes to cmd_pot_o. Bit 1 is ignored.
- R3: The transfer opcodes are 1101, 1110, 0001 and 1000. Each gives exactly one cmd_valid_o pulse after the 16th rising SCK edge, and all later bits of the frame are ignored.
- R4: The write opcodes are 1010 and 1100. Each gives exactly one cmd_valid_o pulse after the 24th rising SCK edge, with cmd_data_o equal to the third byte received MSB first.
- R5: The read opcodes are 1001 and 1011. Each gives one cmd_valid_o pulse after the 16th rising edge, and rd_data_i is taken in that pulse cycle. The byte leaves on so_o MSB first. Each bit changes after a falling SCK edge, starting with the falling edge that follows the 16th rising edge. Zeros follow until select rises.
- R6: Opcode 0101 (status) gives no command. Its third byte on so_o is seven zeros followed by wip_i in the LSB.
- R7: Opcode 0010 (step) gives no command. Each later rising SCK gives one step_valid_o pulse with step_up_o equal to SI (1 = toward the high end, 0 = toward the low end), until select rises.
- R8: Pulling hold_n_i low while SCK is low freezes the frame. SCK edges are then ignored and SO is released. Raising hold_n_i while SCK is low resumes the frame with nothing lost.
- R9: so_oe_o is low whenever select is high and whenever the frame is not in its read-out phase.
- R10: After reset, no frame is accepted until select has made a high-to-low transition, even if select is already low when reset ends.
- R11: The opcodes 0000, 0011, 0100, 0110, 0111 and 1111 are undefined. They give no command and no step, SO stays released, and the rest of the frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Active-low select |
| hold_n_i | input | 1 | Active-low pause |
| addr_strap_i | input | 2 | Device address straps |
| wip_i | input | 1 | Write-busy flag from the register bank |
| rd_data_i | input | 8 | Read byte from the bank, valid while the read command pulses |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Decoded opcode |
| cmd_reg_o | output | 2 | Data-register select |
| cmd_pot_o | output | 1 | Potentiometer select |
| cmd_data_o | output | 8 | Write data byte |
| step_valid_o | output | 1 | One-cycle step strobe |
| step_up_o | output | 1 | Step direction, 1 = up |

## Verification
The assertions assume the system clock runs at least eight times faster than SCK. They also assume that select and the pause input change only while SCK is low, and that SI is steady around each rising SCK edge. Under those conditions a rising or falling SCK edge cannot coincide with a pause transition, and a command strobe always follows one synchronized rising edge. The stimulus keeps each SCK phase at five system clocks and drives every input on the falling system-clock edge. It moves select and the pause line only during SCK-low phases, and it leaves several clocks after each pause transition before the next SCK edge.

// File: rtl/potspi_pkg.sv
package potspi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [2:0] {
    CL_BAD, CL_XFER, CL_WRITE, CL_READ, CL_STATUS, CL_STEP
  } op_class_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_ID, FR_INSTR, FR_WDATA, FR_RDATA, FR_STEP, FR_DONE
  } frame_e;

  // Opcode to behaviour class.
  function automatic op_class_e classify(input logic [3:0] op);
    case (op)
      4'b1101, 4'b1110, 4'b0001, 4'b1000: return CL_XFER;
      4'b1010, 4'b1100:                   return CL_WRITE;
      4'b1001, 4'b1011:                   return CL_READ;
      4'b0101:                            return CL_STATUS;
      4'b0010:                            return CL_STEP;
      default:                            return CL_BAD;
    endcase
  endfunction

  // Identification byte check against the straps.
  function automatic logic id_match(input logic [BYTE_W-1:0] b, input logic [1:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[3:2] == 2'b00) && (b[1:0] == strap);
  endfunction
endpackage

// File: rtl/potspi_sync.sv
module potspi_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/potspi_edges.sv
module potspi_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic held_o
);
  logic sck_d, cs_d, held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
      // Pause enters and leaves only while SCK is low.
      if (!sck_s) begin
        if (!held && !hold_n_s && !cs_n_s) held <= 1'b1;
        else if (held && hold_n_s)         held <= 1'b0;
      end
      if (cs_n_s) held <= 1'b0;
    end
  end

  assign sck_rise_o = sck_s & ~sck_d & ~held;
  assign sck_fall_o = ~sck_s & sck_d & ~held;
  assign cs_fall_o  = cs_d & ~cs_n_s;
  assign held_o     = held;
endmodule

// File: rtl/potspi_frame.sv
module potspi_frame
  import potspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              si_s,
  input  logic              cs_n_s,
  input  logic              cs_fall,
  input  logic [1:0]        strap,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic [1:0]        cmd_reg_o,
  output logic              cmd_pot_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              step_valid_o,
  output logic              step_up_o,
  output logic              ld_rd_o,
  output logic              ld_st_o,
  output logic              out_phase_o,
  output logic              armed_o
);
  frame_e            state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shin;
  logic [BYTE_W-1:0] shin_nx;
  logic              byte_end;
  op_class_e         cls_nx;

  assign shin_nx  = {shin[BYTE_W-2:0], si_s};
  assign byte_end = (bit_cnt == CNT_W'(BYTE_W-1));
  assign cls_nx   = classify(shin_nx[7:4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= FR_IDLE;
      bit_cnt      <= '0;
      shin         <= '0;
      armed_o      <= 1'b0;
      cmd_valid_o  <= 1'b0;
      cmd_op_o     <= '0;
      cmd_reg_o    <= '0;
      cmd_pot_o    <= 1'b0;
      cmd_data_o   <= '0;
      step_valid_o <= 1'b0;
      step_up_o    <= 1'b0;
      ld_rd_o      <= 1'b0;
      ld_st_o      <= 1'b0;
    end else begin
      cmd_valid_o  <= 1'b0;
      step_valid_o <= 1'b0;
      ld_rd_o      <= 1'b0;
      ld_st_o      <= 1'b0;
      if (cs_n_s) begin
        state   <= FR_IDLE;
        bit_cnt <= '0;
      end else if (cs_fall) begin
        armed_o <= 1'b1;
        state   <= FR_ID;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        case (state)
          FR_ID, FR_INSTR, FR_WDATA: begin
            shin    <= shin_nx;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_end) begin
              if (state == FR_ID) begin
                state <= id_match(shin_nx, strap) ? FR_INSTR : FR_DONE;
              end else if (state == FR_INSTR) begin
                if (cls_nx != CL_BAD) begin
                  cmd_op_o  <= shin_nx[7:4];
                  cmd_reg_o <= shin_nx[3:2];
                  cmd_pot_o <= shin_nx[0];
                end
                case (cls_nx)
                  CL_XFER:   begin cmd_valid_o <= 1'b1; state <= FR_DONE; end
                  CL_WRITE:  state <= FR_WDATA;
                  CL_READ:   begin cmd_valid_o <= 1'b1; ld_rd_o <= 1'b1; state <= FR_RDATA; end
                  CL_STATUS: begin ld_st_o <= 1'b1; state <= FR_RDATA; end
                  CL_STEP:   state <= FR_STEP;
                  default:   state <= FR_DONE;
                endcase
              end else begin
                cmd_data_o  <= shin_nx;
                cmd_valid_o <= 1'b1;
                state       <= FR_DONE;
              end
            end
          end
          FR_STEP: begin
            step_valid_o <= 1'b1;
            step_up_o    <= si_s;
          end
          default: ;
        endcase
      end
    end
  end

  assign out_phase_o = (state == FR_RDATA);
endmodule

// File: rtl/potspi_shout.sv
module potspi_shout
  import potspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_fall,
  input  logic              out_phase,
  input  logic              held,
  input  logic              cs_n_s,
  input  logic              ld_rd,
  input  logic              ld_st,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wip,
  output logic              so_o,
  output logic              so_oe_o
);
  logic [BYTE_W-1:0] shreg;
  logic              so_q, driving;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      so_q    <= 1'b0;
      driving <= 1'b0;
    end else begin
      if (ld_rd)      shreg <= rd_data;
      else if (ld_st) shreg <= {{(BYTE_W-1){1'b0}}, wip};
      else if (sck_fall && out_phase) begin
        so_q    <= shreg[BYTE_W-1];
        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
        driving <= 1'b1;
      end
      if (!out_phase) driving <= 1'b0;
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = driving & ~held & ~cs_n_s;
endmodule

// File: rtl/potspi_front.sv
module potspi_front
  import potspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic [1:0]        addr_strap_i,
  input  logic              wip_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic [1:0]        cmd_reg_o,
  output logic              cmd_pot_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              step_valid_o,
  output logic              step_up_o
);
  logic [3:0] pins_s;
  logic sck_s, si_s, cs_n_s, hold_n_s;
  logic sck_rise, sck_fall, cs_fall, held;
  logic ld_rd, ld_st, out_phase, armed;

  // Select resets low so a select held low through reset is not a fall.
  potspi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({hold_n_i, cs_n_i, si_i, sck_i}),
    .q_o(pins_s)
  );
  assign {hold_n_s, cs_n_s, si_s, sck_s} = pins_s;

  potspi_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_fall_o(cs_fall), .held_o(held)
  );

  potspi_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .si_s(si_s), .cs_n_s(cs_n_s),
    .cs_fall(cs_fall), .strap(addr_strap_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_reg_o(cmd_reg_o),
    .cmd_pot_o(cmd_pot_o), .cmd_data_o(cmd_data_o),
    .step_valid_o(step_valid_o), .step_up_o(step_up_o),
    .ld_rd_o(ld_rd), .ld_st_o(ld_st), .out_phase_o(out_phase), .armed_o(armed)
  );

  potspi_shout u_shout (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .out_phase(out_phase), .held(held),
    .cs_n_s(cs_n_s), .ld_rd(ld_rd), .ld_st(ld_st), .rd_data(rd_data_i), .wip(wip_i),
    .so_o(so_o), .so_oe_o(so_oe_o)
  );

  // Strobes only ever follow a synchronized rising SCK edge.
  p_cmd_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(sck_rise));

  // Commands and steps are mutually exclusive.
  p_cmd_step_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, step_valid_o}));

  // No activity before the first select fall.
  p_unarmed_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!cmd_valid_o && !step_valid_o && !so_oe_o));

  // A paused frame produces nothing.
  p_held_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(held) |-> (!step_valid_o && !cmd_valid_o));

  // Driven SO only changes after a falling SCK edge.
  p_so_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe_o && $past(so_oe_o) && (so_o != $past(so_o))) |-> $past(sck_fall));

  // Output enable needs select low (R9).
  p_oe_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe_o |-> !$past(cs_n_s) || !cs_n_s);
endmodule

// File: tb/sim_potspi_front.sv
module sim_potspi_front;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1, wip = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [7:0] rd_data;
  logic so, so_oe, cmd_valid, cmd_pot, step_valid, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg;
  logic [7:0] cmd_data;

  function automatic logic [7:0] bank(input logic [3:0] op, input logic [1:0] rg, input logic p);
    return 8'h5A ^ {op, rg, 1'b0, p};
  endfunction
  assign rd_data = bank(cmd_op, cmd_reg, cmd_pot);

  potspi_front u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .addr_strap_i(strap), .wip_i(wip), .rd_data_i(rd_data),
    .so_o(so), .so_oe_o(so_oe), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_reg_o(cmd_reg), .cmd_pot_o(cmd_pot), .cmd_data_o(cmd_data),
    .step_valid_o(step_valid), .step_up_o(step_up)
  );

  int n_cmd = 0, n_up = 0, n_dn = 0, n_oe = 0;
  logic [3:0] m_op = '0;
  logic [1:0] m_reg = '0;
  logic m_pot = 1'b0;
  logic [7:0] m_data = '0;
  always @(posedge clk) begin
    if (cmd_valid) begin
      n_cmd <= n_cmd + 1; m_op <= cmd_op; m_reg <= cmd_reg; m_pot <= cmd_pot; m_data <= cmd_data;
    end
    if (step_valid && step_up)  n_up <= n_up + 1;
    if (step_valid && !step_up) n_dn <= n_dn + 1;
    if (so_oe) n_oe <= n_oe + 1;
  end

  int n_checks = 0, n_fail = 0;
  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic r);
    si = b;
    tick(HALF);
    r = so;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic do_hold();
    hold_n = 1'b0;
    tick(6);
    check("R8", "SO released while paused", int'(so_oe), 0);
    for (int k = 0; k < 2; k++) begin
      si = ~si; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    hold_n = 1'b1;
    tick(6);
  endtask

  task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                           input int hbyte, input int hbit, output logic [7:0] rx);
    logic [7:0] bs [3];
    logic r;
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    rx = '0;
    cs_n = 1'b0;
    tick(HALF);
    for (int j = 0; j < 3; j++) begin
      for (int i = 7; i >= 0; i--) begin
        if (j == hbyte && i == hbit) do_hold();
        send_bit(bs[j][i], r);
        if (j == 2) rx[i] = r;
      end
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(12);
    check("R9", "SO released after select rises", int'(so_oe), 0);
  endtask

  // 1 transfer, 2 write, 3 read, 4 status, 5 step, 0 undefined
  function automatic int op_kind(input logic [3:0] op);
    case (op)
      4'hD, 4'hE, 4'h1, 4'h8: return 1;
      4'hA, 4'hC:             return 2;
      4'h9, 4'hB:             return 3;
      4'h5:                   return 4;
      4'h2:                   return 5;
      default:                return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int c0, o0, u0c, d0c;
    logic [7:0] rx;
    logic r;

    // R10: select low through reset, a full frame without a falling edge.
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check("R9", "SO released after reset", int'(so_oe), 0);
    check("R10", "no command in reset state", int'(cmd_valid), 0);
    c0 = n_cmd; o0 = n_oe;
    begin
      logic [23:0] f = {8'b0101_0000, 8'b1010_0000, 8'h3C};
      for (int i = 23; i >= 0; i--) send_bit(f[i], r);
    end
    tick(10);
    check("R10", "no command before select falls", n_cmd - c0, 0);
    check("R10", "SO idle before select falls", n_oe - o0, 0);
    cs_n = 1'b1;
    tick(12);

    // R1: address sweep with a wiper write.
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        logic [7:0] d = 8'h40 | 8'(s * 4 + a);
        strap = 2'(s);
        c0 = n_cmd;
        run_frame({4'b0101, 2'b00, 2'(a)}, 8'b1010_0001, d, -1, -1, rx);
        check("R1", "command count for strap/address pair", n_cmd - c0, (s == a) ? 1 : 0);
        if (s == a) check("R4", "write data after address match", int'(m_data), int'(d));
      end
    end
    strap = 2'b10;
    c0 = n_cmd; o0 = n_oe;
    run_frame(8'b0111_0010, 8'b1010_0001, 8'h11, -1, -1, rx);
    check("R1", "wrong device type ignored", n_cmd - c0, 0);
    run_frame(8'b0101_1010, 8'b1001_0001, 8'h11, -1, -1, rx);
    check("R1", "nonzero bits 3:2 ignored", n_cmd - c0, 0);
    check("R1", "SO idle on mismatch", n_oe - o0, 0);

    // Opcode sweep over all sixteen values.
    for (int i = 0; i < 16; i++) begin
      logic [3:0] op = 4'(i);
      logic [1:0] rg = 2'(i * 3);
      logic p = 1'(i);
      logic [7:0] b2 = 8'h96 ^ 8'(i * 11);
      int kind = op_kind(op);
      wip = 1'(i >> 1);
      c0 = n_cmd; o0 = n_oe; u0c = n_up; d0c = n_dn;
      run_frame(8'b0101_0010, {op, rg, 1'b1, p}, b2, -1, -1, rx);
      case (kind)
        1: begin
          check("R3", "transfer gives one command", n_cmd - c0, 1);
          check("R3", "transfer opcode", int'(m_op), int'(op));
        end
        2: begin
          check("R4", "write gives one command", n_cmd - c0, 1);
          check("R4", "write data byte", int'(m_data), int'(b2));
        end
        3: begin
          check("R5", "read gives one command", n_cmd - c0, 1);
          check("R5", "read byte on SO", int'(rx), int'(bank(op, rg, p)));
        end
        4: begin
          check("R6", "status gives no command", n_cmd - c0, 0);
          check("R6", "status byte on SO", int'(rx), int'({7'b0, wip}));
        end
        5: begin
          check("R7", "step gives no command", n_cmd - c0, 0);
          check("R7", "up steps", n_up - u0c, $countones(b2));
          check("R7", "down steps", n_dn - d0c, 8 - $countones(b2));
        end
        default: begin
          check("R11", "undefined opcode gives no command", n_cmd - c0, 0);
          check("R11", "undefined opcode gives no step", (n_up - u0c) + (n_dn - d0c), 0);
        end
      endcase
      if (kind >= 1 && kind <= 3) begin
        check("R2", "register select field", int'(m_reg), int'(rg));
        check("R2", "pot select field", int'(m_pot), int'(p));
      end
      if (kind == 3 || kind == 4) check("R5", "SO driven during read-out", int'(n_oe > o0), 1);
      else check("R9", "SO idle outside read-out", n_oe - o0, 0);
    end

    // R8: pause inside the read-out byte and inside the instruction byte.
    run_frame(8'b0101_0010, 8'b1011_1001, 8'h00, 2, 4, rx);
    check("R8", "read byte intact across pause", int'(rx), int'(bank(4'b1011, 2'b10, 1'b1)));
    c0 = n_cmd;
    run_frame(8'b0101_0010, 8'b1100_0101, 8'hA7, 1, 3, rx);
    check("R8", "write intact across pause", n_cmd - c0, 1);
    check("R8", "write data across pause", int'(m_data), 8'hA7);
    check("R8", "register field across pause", int'(m_reg), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule